// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of a single-bank parallel NOR flash and turns one-shot program and sector-erase requests into the command write sequences the flash expects. Each request is given as an operation, a target address and a data value, with a one-cycle start pulse. The sequencer then owns the flash bus until the operation has completed, has been refused, or has timed out. At that point it pulses `done` and reports the outcome on `err`.

Program requests are checked first. The current word is read, and a request that would need any bit to go from 0 to 1 is refused before anything is written to the flash. Completion of both operations is found by polling data bit 7. During an erase, an interrupt-request input can pause the work: the sequencer suspends the erase, waits with the bus quiet until the request drops, and then resumes the erase and goes back to polling. A programmable limit bounds every polling loop.

Top module: `nor_cmd_seq`

## Requirements
- R1: A program request issues exactly four bus writes, in this order: 0xAA to offset 0xAAAA, 0x55 to offset 0x5555, 0xA0 to offset 0xAAAA, then the data value to the target address.
- R2: A sector erase issues exactly six bus writes, in this order: 0xAA@0xAAAA, 0x55@0x5555, 0x80@0xAAAA, 0xAA@0xAAAA, 0x55@0x5555, then 0x30 to the sector address.
- R3: A program completes when a read of the target returns bit 7 equal to bit 7 of the written value. `done` is then high for exactly one cycle with `err` low, and `busy` is high from the cycle after start up to and including that cycle.
- R4: Before programming, the target word is read once. If any bit is 0 in the stored word and 1 in the new value, no bus write occurs and the request ends with `err` high.
- R5: An erase completes when a poll read of the sector address returns bit 7 equal to 1.
- R6: If the interrupt request is high after a failed erase poll, 0xB0 is written to the sector address and polled until bit 7 is 1. `sus_pend` is high from the 0xB0 write cycle until the cycle after the resume write. `suspended` is high from the confirmed suspend until the same point, and is never high without `sus_pend`.
- R7: While suspended and while the interrupt request stays high, no bus write occurs. After the request drops, one read of the sector is made, 0x30 is written to the sector address, and erase polling continues until completion.
- R8: With limit L on `tmo_limit`, a polling loop that fails L+1 consecutive times ends the request with `err` high and issues no further bus write.
- R9: Each write is a single cycle with `fl_we` high. `fl_we` and `fl_re` are never high together, and neither is high when `busy` is low.
- R10: After reset, `busy`, `done`, `err`, `sus_pend`, `suspended`, `fl_we` and `fl_re` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | One-cycle request pulse, accepted while idle |
| req_op | input | 1 | 0 = program, 1 = sector erase |
| req_addr | input | AW | Target word or sector address |
| req_data | input | DW | Value to program |
| tmo_limit | input | TW | Poll limit L; a loop aborts after L+1 failed polls |
| irq | input | 1 | Interrupt request; suspends a running erase |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Outcome of the last request, valid from `done` onward |
| sus_pend | output | 1 | Suspend sequence in progress |
| suspended | output | 1 | Erase confirmed suspended |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Flash write data |
| fl_we | output | 1 | Write strobe |
| fl_re | output | 1 | Read strobe; data is returned on the next cycle |
| fl_rdata | input | DW | Flash read data |

## Verification
The bound checker watches the bus handshake and the status outputs on every cycle. It checks that the strobes are exclusive and quiet while idle, that `done` is a single-cycle pulse inside `busy`, and that `suspended` never appears without `sus_pend`. It also checks that `sus_pend` rises only on a 0xB0 write and falls only after a 0x30 write. The exact write order of each command, the 0-to-1 refusal, polling on the correct polarity of bit 7, the silent hold during an interrupt, and the timeout count can only be shown by the bench. The bench does this against a behavioural flash that logs every write and models program and erase latency.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE_RD,
        S_PRE_SMP,
        S_CMD,
        S_POLL_RD,
        S_POLL_SMP,
        S_SUS_WR,
        S_SUS_RD,
        S_SUS_SMP,
        S_HOLD,
        S_RES_RD,
        S_RES_SMP,
        S_RES_WR,
        S_DONE
    } st_e;

    localparam logic [15:0] OFF_A = 16'hAAAA;
    localparam logic [15:0] OFF_B = 16'h5555;
    localparam logic [7:0]  KEY_A = 8'hAA;
    localparam logic [7:0]  KEY_B = 8'h55;
    localparam logic [7:0]  C_PROG  = 8'hA0;
    localparam logic [7:0]  C_ERSET = 8'h80;
    localparam logic [7:0]  C_GO    = 8'h30;
    localparam logic [7:0]  C_PAUSE = 8'hB0;
    localparam int          STAT_BIT = 7;

    // one write step of a command sequence
    typedef struct packed {
        logic [15:0] off;
        logic [7:0]  code;
        logic        at_tgt;
        logic        use_val;
        logic        last;
    } step_t;

    function automatic step_t cmd_step(op_e op, logic [2:0] idx);
        step_t s;
        s = '{off: OFF_A, code: KEY_A, at_tgt: 1'b0, use_val: 1'b0, last: 1'b0};
        if (op == OP_PROG) begin
            case (idx)
                3'd0: s.code = KEY_A;
                3'd1: begin s.off = OFF_B; s.code = KEY_B; end
                3'd2: s.code = C_PROG;
                default: begin s.at_tgt = 1'b1; s.use_val = 1'b1; s.last = 1'b1; end
            endcase
        end else begin
            case (idx)
                3'd0, 3'd3: s.code = KEY_A;
                3'd1, 3'd4: begin s.off = OFF_B; s.code = KEY_B; end
                3'd2: s.code = C_ERSET;
                default: begin s.at_tgt = 1'b1; s.code = C_GO; s.last = 1'b1; end
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick && cnt != '1)
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt >= limit);
endmodule

// File: rtl/nor_bus_drv.sv
module nor_bus_drv
    import nor_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  st_e           st,
    input  step_t         step,
    input  logic [AW-1:0] tgt,
    input  logic [DW-1:0] val,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          we,
    output logic          re
);
    always_comb begin
        addr  = tgt;
        wdata = '0;
        we    = 1'b0;
        re    = 1'b0;
        unique case (st)
            S_PRE_RD, S_POLL_RD, S_SUS_RD, S_RES_RD: re = 1'b1;
            S_CMD: begin
                we    = 1'b1;
                addr  = step.at_tgt  ? tgt : AW'(step.off);
                wdata = step.use_val ? val : DW'(step.code);
            end
            S_SUS_WR: begin we = 1'b1; wdata = DW'(C_PAUSE); end
            S_RES_WR: begin we = 1'b1; wdata = DW'(C_GO); end
            default: ;
        endcase
    end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_start,
    input  logic          req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [TW-1:0] tmo_limit,
    input  logic          irq,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          sus_pend,
    output logic          suspended,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    output logic          fl_we,
    output logic          fl_re,
    input  logic [DW-1:0] fl_rdata
);
    st_e           st;
    op_e           op_q;
    logic [2:0]    idx;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          err_q, pend_q, susp_q;
    logic          t_clr, t_tick, t_exp;
    step_t         step;
    logic          stat, poll_ok, clash;

    assign step    = cmd_step(op_q, idx);
    assign stat    = fl_rdata[STAT_BIT];
    assign poll_ok = (op_q == OP_PROG) ? (stat == data_q[STAT_BIT]) : stat;
    assign clash   = |(~fl_rdata & data_q);

    nor_poll_timer #(.CW(TW)) u_tmr (
        .clk(clk), .rst(rst), .clr(t_clr), .tick(t_tick),
        .limit(tmo_limit), .expired(t_exp)
    );

    nor_bus_drv #(.AW(AW), .DW(DW)) u_bus (
        .st(st), .step(step), .tgt(addr_q), .val(data_q),
        .addr(fl_addr), .wdata(fl_wdata), .we(fl_we), .re(fl_re)
    );

    always_comb begin
        t_clr  = 1'b0;
        t_tick = 1'b0;
        case (st)
            S_CMD:      t_clr  = step.last;
            S_SUS_WR,
            S_RES_WR:   t_clr  = 1'b1;
            S_POLL_SMP: t_tick = !poll_ok;
            S_SUS_SMP:  t_tick = !stat;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            op_q   <= OP_PROG;
            idx    <= '0;
            addr_q <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
            pend_q <= 1'b0;
            susp_q <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (req_start) begin
                    op_q   <= op_e'(req_op);
                    addr_q <= req_addr;
                    data_q <= req_data;
                    idx    <= '0;
                    err_q  <= 1'b0;
                    st     <= (op_e'(req_op) == OP_PROG) ? S_PRE_RD : S_CMD;
                end
                S_PRE_RD:  st <= S_PRE_SMP;
                S_PRE_SMP: begin
                    if (clash) begin
                        err_q <= 1'b1;
                        st    <= S_DONE;
                    end else begin
                        st <= S_CMD;
                    end
                end
                S_CMD: begin
                    if (step.last) st  <= S_POLL_RD;
                    else           idx <= idx + 1'b1;
                end
                S_POLL_RD:  st <= S_POLL_SMP;
                S_POLL_SMP: begin
                    if (poll_ok) begin
                        st <= S_DONE;
                    end else if (op_q == OP_ERASE && irq) begin
                        pend_q <= 1'b1;
                        st     <= S_SUS_WR;
                    end else if (t_exp) begin
                        err_q <= 1'b1;
                        st    <= S_DONE;
                    end else begin
                        st <= S_POLL_RD;
                    end
                end
                S_SUS_WR:  st <= S_SUS_RD;
                S_SUS_RD:  st <= S_SUS_SMP;
                S_SUS_SMP: begin
                    if (stat) begin
                        susp_q <= 1'b1;
                        st     <= S_HOLD;
                    end else if (t_exp) begin
                        err_q  <= 1'b1;
                        pend_q <= 1'b0;
                        st     <= S_DONE;
                    end else begin
                        st <= S_SUS_RD;
                    end
                end
                S_HOLD:    if (!irq) st <= S_RES_RD;
                S_RES_RD:  st <= S_RES_SMP;
                S_RES_SMP: st <= S_RES_WR;
                S_RES_WR: begin
                    pend_q <= 1'b0;
                    susp_q <= 1'b0;
                    st     <= S_POLL_RD;
                end
                S_DONE:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy      = (st != S_IDLE);
    assign done      = (st == S_DONE);
    assign err       = err_q;
    assign sus_pend  = pend_q;
    assign suspended = susp_q;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          sus_pend,
    input logic          suspended,
    input logic          fl_we,
    input logic          fl_re,
    input logic [DW-1:0] fl_wdata
);
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_re));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!fl_we && !fl_re));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_in_busy_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    p_susp_in_pend_r6: assert property (@(posedge clk) disable iff (rst)
        suspended |-> sus_pend);

    p_pend_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sus_pend) |-> (fl_we && fl_wdata[7:0] == 8'hB0));

    p_pend_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(sus_pend) && !done |-> ($past(fl_we) && $past(fl_wdata[7:0]) == 8'h30));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .sus_pend(sus_pend),
    .suspended(suspended), .fl_we(fl_we), .fl_re(fl_re), .fl_wdata(fl_wdata)
);

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_start = 1'b0;
    logic        req_op = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic [15:0] tmo_limit = 16'd20;
    logic        irq = 1'b0;
    logic        busy, done, err, sus_pend, suspended, fl_we, fl_re;
    logic [15:0] fl_addr, fl_wdata;
    logic [15:0] fl_rdata = '0;

    always #4 clk = ~clk;

    nor_cmd_seq u_dut (
        .clk(clk), .rst(rst), .req_start(req_start), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .tmo_limit(tmo_limit),
        .irq(irq), .busy(busy), .done(done), .err(err), .sus_pend(sus_pend),
        .suspended(suspended), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
    );

    // behavioural flash with write log
    logic [15:0] mem [16];
    logic [15:0] log_a [32];
    logic [15:0] log_d [32];
    int          logn = 0;
    int          rdn = 0;
    int          lat = 0;
    int          busy_n = 0;
    logic        arm = 0, is_prog = 0, m_susp = 0, seen80 = 0;
    logic [15:0] pval = '0;

    always @(posedge clk) begin
        if (fl_we) begin
            if (logn < 32) begin
                log_a[logn] = fl_addr;
                log_d[logn] = fl_wdata;
            end
            logn = logn + 1;
            if (arm) begin
                mem[fl_addr[3:0]] = mem[fl_addr[3:0]] & fl_wdata;
                pval = fl_wdata; is_prog = 1; busy_n = lat; arm = 0;
            end else if (fl_addr == 16'hAAAA && fl_wdata == 16'h00A0) arm = 1;
            else if (fl_wdata == 16'h0080) seen80 = 1;
            else if (fl_wdata == 16'h00B0) m_susp = 1;
            else if (fl_wdata == 16'h0030) begin
                if (m_susp) m_susp = 0;
                else if (seen80) begin
                    mem[fl_addr[3:0]] = 16'hFFFF;
                    is_prog = 0; busy_n = lat; seen80 = 0;
                end
            end
        end
        if (fl_re) begin
            rdn = rdn + 1;
            if (m_susp) fl_rdata <= 16'h0080;
            else if (busy_n > 0) begin
                busy_n = busy_n - 1;
                fl_rdata <= is_prog ? {8'h00, ~pval[7], 7'h00} : 16'h0000;
            end else fl_rdata <= mem[fl_addr[3:0]];
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_wr(input bit op, input int i,
                                           input logic [15:0] a, input logic [15:0] v);
        if (!op) begin
            case (i)
                0: return {16'hAAAA, 16'h00AA};
                1: return {16'h5555, 16'h0055};
                2: return {16'hAAAA, 16'h00A0};
                default: return {a, v};
            endcase
        end
        case (i)
            0, 3: return {16'hAAAA, 16'h00AA};
            1, 4: return {16'h5555, 16'h0055};
            2: return {16'hAAAA, 16'h0080};
            default: return {a, 16'h0030};
        endcase
    endfunction

    logic got_err;
    int   busy_len;

    task automatic run_op(input bit op, input logic [15:0] a, input logic [15:0] v);
        int w;
        @(negedge clk);
        logn = 0; rdn = 0;
        req_op = op; req_addr = a; req_data = v; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        w = 0; busy_len = 1;
        while (!done && w < 5000) begin
            @(negedge clk); w++;
            if (busy) busy_len++;
        end
        got_err = err;
        chk(w < 5000, "R3", "done seen", w, 0);
        @(negedge clk);
    endtask

    typedef struct packed {
        logic        op;
        logic [15:0] addr;
        logic [15:0] pre;
        logic [15:0] val;
        logic [7:0]  lat;
        logic        e_err;
        logic [3:0]  e_n;
        logic [15:0] e_mem;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0003, 16'hFFFF, 16'h1234, 8'd3, 1'b0, 4'd4, 16'h1234},
        '{1'b0, 16'h0005, 16'h00F0, 16'h0F00, 8'd3, 1'b1, 4'd0, 16'h00F0},
        '{1'b0, 16'h0006, 16'hFF0F, 16'h0F0F, 8'd0, 1'b0, 4'd4, 16'h0F0F},
        '{1'b0, 16'h0007, 16'hFFFF, 16'h00FF, 8'd5, 1'b0, 4'd4, 16'h00FF},
        '{1'b1, 16'h0008, 16'h1234, 16'h0000, 8'd6, 1'b0, 4'd6, 16'hFFFF},
        '{1'b1, 16'h0009, 16'h0000, 16'h0000, 8'd0, 1'b0, 4'd6, 16'hFFFF}
    };

    initial begin
        while (cyc < 150000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !err, "R10", "status after reset", {busy, done, err}, 0);
        chk(!sus_pend && !suspended, "R10", "suspend flags after reset", {sus_pend, suspended}, 0);
        chk(!fl_we && !fl_re, "R10", "strobes after reset", {fl_we, fl_re}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !fl_we && !fl_re, "R9", "idle bus quiet", {busy, fl_we, fl_re}, 0);

        // table walk: R1 R2 R3 R4 R5
        for (int k = 0; k < NV; k++) begin
            mem[VECS[k].addr[3:0]] = VECS[k].pre;
            lat = int'(VECS[k].lat);
            run_op(VECS[k].op, VECS[k].addr, VECS[k].val);
            chk(got_err == VECS[k].e_err, VECS[k].e_err ? "R4" : "R3", "err", got_err, VECS[k].e_err);
            chk(logn == int'(VECS[k].e_n), VECS[k].op ? "R2" : "R1", "write count", logn, VECS[k].e_n);
            for (int j = 0; j < int'(VECS[k].e_n) && j < logn; j++) begin
                logic [31:0] e;
                e = exp_wr(VECS[k].op, j, VECS[k].addr, VECS[k].val);
                chk({log_a[j], log_d[j]} == e, VECS[k].op ? "R2" : "R1", "write entry",
                    {log_a[j], log_d[j]}, e);
            end
            chk(mem[VECS[k].addr[3:0]] == VECS[k].e_mem, VECS[k].op ? "R5" : "R3", "final word",
                mem[VECS[k].addr[3:0]], VECS[k].e_mem);
            chk(!busy && !done, "R3", "back to idle", {busy, done}, 0);
        end

        // R3: done pulse inside busy; program with 2 busy polls -> busy spans start..done
        mem[1] = 16'hFFFF; lat = 2;
        run_op(1'b0, 16'h0001, 16'h0081);
        // pre-read 2 + 4 writes + 3 polls x 2 + done 1 = 13 busy cycles
        chk(busy_len == 13, "R3", "busy length", busy_len, 13);

        // R8: timeout with limit 3 -> 4 failed polls, one pre-read
        tmo_limit = 16'd3; mem[2] = 16'hFFFF; lat = 200;
        run_op(1'b0, 16'h0002, 16'h0055);
        chk(got_err == 1'b1, "R8", "timeout err", got_err, 1);
        chk(rdn == 5, "R8", "reads before abort", rdn, 5);
        chk(logn == 4, "R8", "no write after abort", logn, 4);
        busy_n = 0; tmo_limit = 16'd100;

        // R6 R7: erase suspended by irq, then resumed
        mem[10] = 16'h0000; lat = 30;
        @(negedge clk);
        logn = 0; rdn = 0;
        req_op = 1'b1; req_addr = 16'h000A; req_start = 1'b1; irq = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        begin
            int w;
            int ln;
            w = 0;
            while (!suspended && w < 200) begin @(negedge clk); w++; end
            chk(suspended && sus_pend, "R6", "suspend confirmed", {suspended, sus_pend}, 3);
            chk(logn == 7 && log_d[6] == 16'h00B0 && log_a[6] == 16'h000A, "R6",
                "suspend write", log_d[6], 16'h00B0);
            ln = logn;
            repeat (12) @(negedge clk);
            chk(logn == ln, "R7", "no writes while held", logn, ln);
            chk(busy && suspended, "R7", "still held", {busy, suspended}, 3);
            irq = 1'b0;
            w = 0;
            while (!done && w < 2000) begin @(negedge clk); w++; end
            chk(done && !err, "R5", "erase done after resume", {done, err}, 2);
            chk(logn == 8 && log_d[7] == 16'h0030 && log_a[7] == 16'h000A, "R7",
                "resume write", log_d[7], 16'h0030);
            chk(!sus_pend && !suspended, "R6", "flags cleared", {sus_pend, suspended}, 0);
            chk(mem[10] == 16'hFFFF, "R5", "sector erased", mem[10], 16'hFFFF);
            @(negedge clk);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule